// File: doc/BRIEF.md
# Zero-Wait Prefetch Read Latch

This block sits between a host bus and a slow shared memory that answers one clock after a read request. It has two read modes, chosen by a mode input. In zero-wait mode the host never sees a wait state. The first read of a 32-bit word is a dummy read. It starts a fetch from memory into a holding latch, and the data returned on that read carries no meaning. Reads that follow to any byte address inside the same word are answered in the same cycle from the latch. A read whose word differs from the latched word counts as a fresh dummy read and reloads the latch. Reading a whole word therefore takes five host reads on an 8-bit bus and three on a 16-bit bus.

When the mode input is low, the block works as a plain wait-state interface. A read holds the host off with a low ready output until the registered memory data arrives. Ready is then raised for exactly one cycle, with the selected slice of the word on the data output. Reads in this mode do not touch the latch.

Top module: `zw_read_latch`

## Requirements
- R1: After reset the latch holds nothing. The first zero-wait read after any reset issues a memory fetch, even to a word fetched before the reset. In wait mode with no read pending, `rd_ready` is 0 after reset.
- R2: A zero-wait read that misses the latched word drives `mem_rd` high for that single cycle, with `mem_addr` equal to `rd_addr` shifted right by two. The fetched word becomes the new latched word.
- R3: A zero-wait read that hits the latched word drives `mem_rd` low and returns its data in the same cycle as `rd_req`. `rd_ready` is 1 throughout zero-wait mode.
- R4: With `bus8`=1, `rd_addr[1:0]` picks one byte of the word: 0 selects bits 7:0, 1 selects 15:8, 2 selects 23:16 and 3 selects 31:24. The byte appears on `rd_data[7:0]` and `rd_data[15:8]` is 0.
- R5: With `bus8`=0, `rd_addr[1]` picks one halfword: 0 selects bits 15:0 and 1 selects 31:16. `rd_addr[0]` is ignored.
- R6: A read of the same word in the cycle right after its dummy read returns the fetched data without a second fetch.
- R7: In wait mode a read drives `rd_ready` low and `mem_rd` high in its first cycle. The next cycle has `rd_ready` high, the selected data on `rd_data` and `mem_rd` low. Ready falls again one cycle later.
- R8: Wait-mode reads leave the latched word and its data unchanged. A later zero-wait read of the latched word still hits.
- R9: After a dummy read of a new word, the previously latched word misses again.
- R10: Switching `bus8` between reads does not invalidate the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zw_en | input | 1 | 1 = zero-wait mode, 0 = wait-state mode |
| bus8 | input | 1 | 1 = 8-bit host bus, 0 = 16-bit host bus |
| rd_req | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host byte address |
| rd_data | output | 16 | Read data slice |
| rd_ready | output | 1 | Read acknowledge / not-stalled |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_rdata | input | 32 | Memory data, valid the cycle after `mem_rd` |

## Verification
The assertions assume the host holds `rd_req` and `rd_addr` steady from the start of a wait-mode read until the cycle in which ready is high. They also assume `zw_en` changes only while no wait-mode read is pending, and that memory data follows a strobe by exactly one cycle. The bench keeps to these rules. It drives every input at the falling edge and changes the mode only between reads. Its memory model registers a computed word one cycle after each strobe. Zero-wait reads are issued back to back, one per cycle, so the bypass in the cycle after a dummy read is exercised as well as hits from the latch itself.

// File: rtl/zw_pkg.sv
// Package: shared widths for the zero-wait read latch.
// Assumes a 32-bit memory word and a host bus of at most 16 bits.
package zw_pkg;
    localparam int WORD_W     = 32;
    localparam int HOST_W     = 16;
    localparam int LANE_W     = 8;
    localparam int LANES      = WORD_W / LANE_W;
    localparam int LANE_SEL_W = $clog2(LANES);
    localparam int HALVES     = WORD_W / HOST_W;
    localparam int HALF_SEL_W = $clog2(HALVES);
endpackage

// File: rtl/zw_slice_sel.sv
// Module: picks one byte or one halfword out of a 32-bit word.
// Assumes little-endian lane order: the lowest address selects the least
// significant lane. In byte mode the upper output bits are zero.
module zw_slice_sel
    import zw_pkg::*;
(
    input  logic [WORD_W-1:0]     word,
    input  logic [LANE_SEL_W-1:0] lane_sel,
    input  logic                  bus8,
    output logic [HOST_W-1:0]     data
);
    logic [LANE_W-1:0] lane [LANES];
    logic [HOST_W-1:0] half [HALVES];

    // Split the word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*LANE_W +: LANE_W];
    end

    // Split the word into halfword lanes.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half[h] = word[h*HOST_W +: HOST_W];
    end

    // Output mux by bus width.
    always_comb begin
        if (bus8)
            data = {{(HOST_W-LANE_W){1'b0}}, lane[lane_sel]};
        else
            data = half[lane_sel[LANE_SEL_W-1 -: HALF_SEL_W]];
    end
endmodule

// File: rtl/zw_latch.sv
// Module: the holding latch with its word tag and the fill that is in flight.
// Assumes memory data is valid exactly one cycle after a fetch strobe.
// Decides hit or miss for zero-wait reads and bypasses data still in flight.
module zw_latch
    import zw_pkg::*;
#(
    parameter int WA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zw_en,
    input  logic              rd_req,
    input  logic [WA_W-1:0]   req_word,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              fetch,
    output logic [WORD_W-1:0] src_data
);
    logic              latch_valid;
    logic [WA_W-1:0]   latch_word;
    logic [WORD_W-1:0] latch_data;
    logic              pend_valid;
    logic [WA_W-1:0]   pend_word;
    logic              hit_pend;
    logic              hit_latch;

    // Hit detection against the latch and against the fill in flight.
    always_comb begin
        hit_pend  = pend_valid  && (pend_word  == req_word);
        hit_latch = latch_valid && (latch_word == req_word);
        fetch     = zw_en && rd_req && !hit_pend && !hit_latch;
        src_data  = hit_pend ? mem_rdata : latch_data;
    end

    // Track the fetch whose data returns next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_word  <= '0;
        end else begin
            pend_valid <= fetch;
            if (fetch)
                pend_word <= req_word;
        end
    end

    // Load the latch when fetched data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_valid <= 1'b0;
            latch_word  <= '0;
            latch_data  <= '0;
        end else if (pend_valid) begin
            latch_valid <= 1'b1;
            latch_word  <= pend_word;
            latch_data  <= mem_rdata;
        end
    end

    AST_PEND_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> $past(fetch));                                   // R2
    AST_FILL_LOADS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> (latch_valid && latch_word == $past(pend_word))); // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |=> ($stable(latch_data) && $stable(latch_word)));  // R8
endmodule

// File: rtl/zw_wait_ctl.sv
// Module: wait-state handshake for reads when zero-wait mode is off.
// Assumes the host holds its request until ready is seen and does not
// change the mode while a read is pending.
module zw_wait_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic zw_en,
    input  logic rd_req,
    output logic start,
    output logic busy
);
    // A new wait-mode read starts only when none is pending.
    always_comb start = !zw_en && rd_req && !busy;

    // Busy marks the cycle in which memory data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= start;
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);                                                // R7
endmodule

// File: rtl/zw_read_latch.sv
// Top: zero-wait read latch with a wait-state fallback.
// Assumes a registered-read memory with one cycle of latency. Zero-wait
// reads are single-cycle; wait-mode reads are held until ready.
module zw_read_latch
    import zw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zw_en,
    input  logic                bus8,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [HOST_W-1:0]   rd_data,
    output logic                rd_ready,
    output logic                mem_rd,
    output logic [ADDR_W-3:0]   mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata
);
    localparam int WA_W = ADDR_W - LANE_SEL_W;

    logic [WA_W-1:0]       req_word;
    logic [LANE_SEL_W-1:0] req_lane;
    logic                  fetch;
    logic [WORD_W-1:0]     latch_src;
    logic                  w_start;
    logic                  w_busy;
    logic [WORD_W-1:0]     slice_src;

    // Split the byte address into word and lane parts.
    always_comb begin
        req_word = rd_addr[ADDR_W-1:LANE_SEL_W];
        req_lane = rd_addr[LANE_SEL_W-1:0];
    end

    zw_latch #(.WA_W(WA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .zw_en     (zw_en),
        .rd_req    (rd_req),
        .req_word  (req_word),
        .mem_rdata (mem_rdata),
        .fetch     (fetch),
        .src_data  (latch_src)
    );

    zw_wait_ctl u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .zw_en  (zw_en),
        .rd_req (rd_req),
        .start  (w_start),
        .busy   (w_busy)
    );

    // Memory strobe, ready and data source by mode.
    always_comb begin
        mem_rd    = fetch || w_start;
        mem_addr  = req_word;
        rd_ready  = zw_en ? 1'b1 : w_busy;
        slice_src = zw_en ? latch_src : mem_rdata;
    end

    zw_slice_sel u_slice (
        .word     (slice_src),
        .lane_sel (req_lane),
        .bus8     (bus8),
        .data     (rd_data)
    );

    AST_WAIT_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!zw_en && mem_rd) |=> (zw_en || rd_ready));                    // R7
    AST_WAIT_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!zw_en && rd_ready) |=> (zw_en || !rd_ready));                 // R7
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && bus8) |-> (rd_data[HOST_W-1:LANE_W] == '0));       // R4
    AST_NO_BACK_TO_BACK_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (zw_en && mem_rd && rd_req) |=> !(zw_en && rd_req && mem_rd &&
            $stable(req_word)));                                        // R6
endmodule

// File: tb/tb_zw_read_latch.sv
module tb_zw_read_latch;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int NVEC = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              zw_en = 1'b0;
    logic              bus8 = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [15:0]       rd_data;
    logic              rd_ready;
    logic              mem_rd;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Vector: {bus8, addr[11:0], miss, expected data[15:0]}; data unchecked on a miss.
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 12'h010, 1'b1, 16'h0000},  // R2 R1 dummy, word 4
        {1'b1, 12'h010, 1'b0, 16'h0004},  // R6 R4 byte 0 via bypass
        {1'b1, 12'h011, 1'b0, 16'h0034},  // R4 byte 1
        {1'b1, 12'h012, 1'b0, 16'h00C4},  // R4 byte 2
        {1'b1, 12'h013, 1'b0, 16'h00F4},  // R4 byte 3
        {1'b0, 12'h2A8, 1'b1, 16'h0000},  // R9 R2 dummy, word AA
        {1'b0, 12'h2A8, 1'b0, 16'h9AAA},  // R5 half 0
        {1'b0, 12'h2AA, 1'b0, 16'h5A6A},  // R5 half 1
        {1'b0, 12'h2A9, 1'b0, 16'h9AAA},  // R5 bit 0 ignored
        {1'b1, 12'h2AB, 1'b0, 16'h005A},  // R10 width change keeps latch
        {1'b1, 12'h010, 1'b1, 16'h0000},  // R9 word 4 misses again
        {1'b1, 12'h012, 1'b0, 16'h00C4},  // R6 bypass
        {1'b0, 12'h2AA, 1'b1, 16'h0000}   // R9 word AA replaced
    };

    zw_read_latch #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .zw_en(zw_en), .bus8(bus8),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_ready(rd_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [ADDR_W-3:0] w);
        logic [7:0] b;
        b = w[7:0];
        return {b ^ 8'hF0, b ^ 8'hC0, b ^ 8'h30, b};
    endfunction

    // Registered-read memory model.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic zw_read(input logic b8, input logic [ADDR_W-1:0] a,
                           input logic miss, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus8 = b8; rd_addr = a; rd_req = 1'b1;
        #1;
        chk({tag, " mem_rd"}, 32'(mem_rd), 32'(miss));
        chk({tag, " ready"}, 32'(rd_ready), 32'd1);
        if (miss) chk({tag, " mem_addr"}, 32'(mem_addr), 32'(a >> 2));
        else      chk({tag, " data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic wt_read(input logic b8, input logic [ADDR_W-1:0] a,
                           input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus8 = b8; rd_addr = a; rd_req = 1'b1;
        #1;
        chk({tag, " R7 ready low"}, 32'(rd_ready), 32'd0);
        chk({tag, " R7 mem_rd"}, 32'(mem_rd), 32'd1);
        @(negedge clk);
        #1;
        chk({tag, " R7 ready high"}, 32'(rd_ready), 32'd1);
        chk({tag, " R7 data"}, 32'(rd_data), 32'(exp));
        chk({tag, " R7 no refetch"}, 32'(mem_rd), 32'd0);
        rd_req = 1'b0;
        @(negedge clk);
        #1;
        chk({tag, " R7 ready falls"}, 32'(rd_ready), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ready idle wait mode", 32'(rd_ready), 32'd0);
        chk("R1 no fetch idle", 32'(mem_rd), 32'd0);
        zw_en = 1'b1;
        #1;
        chk("R3 ready in zero-wait", 32'(rd_ready), 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            zw_read(VEC[i][29], VEC[i][28:17], VEC[i][16], VEC[i][15:0],
                    $sformatf("vec%0d", i));
        end
        @(negedge clk);
        rd_req = 1'b0;

        // Wait-mode reads; latch holds word AA.
        @(negedge clk);
        zw_en = 1'b0;
        wt_read(1'b0, 12'h2AA, 16'h5A6A, "R5 wait half");
        wt_read(1'b1, 12'h011, 16'h0034, "R4 wait byte");
        wt_read(1'b1, 12'h157, 16'h00A5, "R4 wait byte3");

        // R8: latch untouched by wait reads.
        @(negedge clk);
        zw_en = 1'b1;
        zw_read(1'b0, 12'h2A8, 1'b0, 16'h9AAA, "R8 hit after wait reads");
        zw_read(1'b1, 12'h2AA, 1'b0, 16'h006A, "R8 R4 byte2 after wait reads");

        // R1: reset clears the latch.
        @(negedge clk);
        rd_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        zw_read(1'b0, 12'h2A8, 1'b1, 16'h0000, "R1 miss after reset");
        zw_read(1'b0, 12'h2AA, 1'b0, 16'h5A6A, "R1 R6 refill");
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        chk("R3 no fetch when idle", 32'(mem_rd), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule